// File: doc/BRIEF.md
# Switchable Pin Mode Controller

This block steers a group of package pins that can serve either as supply pins or as extra memory-bus signal pins. In the default single-bus state every switchable pin carries supply current and the memory devices behind the borrowed buses are reached through the shared bus. When the memory controller asks for multi-bus operation with a given number of borrowed buses, the block walks through a fixed sequence. It first drops the core operating point to the level allowed by the reduced supply pin count. It then waits out the combined clock, voltage and supply-settling time and opens the supply switches. Only after that does it hand the pins to the signal buffers and switch the device-side selectors to the private buses.

Leaving multi-bus operation runs the same steps backwards. The buffers go quiet, the supply switches close, the operating point comes back to full speed, and the settle window elapses before the single-bus state is reported ready. While buses are borrowed, the per-cycle transfer direction picks which data buffer drives. The command buffer drives in every multi-bus cycle. A request that changes while a sequence is running only takes effect once the block is back in a stable state.

Top module: `pin_mode_ctrl`

## Requirements
- R1: After reset all supply switch enables are 1, all read, write and command buffer enables are 0, every bus selects its shared pair (sel_shared=1, sel_private=0), op_level is 0 and mode_ready is 1.
- R2: In the stable multi-bus state with k borrowed buses, buses 0..k-1 (bit i is bus i) have the supply switch off and the command buffer on, while buses k and above keep the supply switch on with all buffers off.
- R3: On a borrowed bus in the stable multi-bus state, dir_write=0 enables only the read data buffer and dir_write=1 enables only the write data buffer. In the single-bus state dir_write has no effect on any output.
- R4: Each bus has exactly one device-side pair selected. The private pair is selected on borrowed buses from the cycle the supply switches open until the cycle after the buffers are turned off; the shared pair is selected on every other bus and in every other cycle.
- R5: op_level reports the number of borrowed buses (0 means 1 bus at full speed, 3 means 4 buses at the lowest point). A multi-bus request with req_extra=0 leaves the block in the single-bus state.
- R6: No bus ever has its supply switch enabled in the same cycle as any of its buffers, and no bus has the read and write data buffers on together.
- R7: On a multi-bus request seen in the stable single-bus state, op_level takes the new value in the first cycle while all supply switches stay on. The supply switches open SETTLE_CYCLES+1 cycles after the request edge, and mode_ready returns SETTLE_CYCLES+2 clock edges after that edge.
- R8: On leaving multi-bus operation, the buffers turn off at the first edge, the supply switches close at the second, op_level returns to 0 at the third, and mode_ready returns SETTLE_CYCLES+3 edges after the request edge.
- R9: A change of req_multi or req_extra during a sequence does not alter that sequence. The block finishes it, reports ready for one cycle, and then leaves for the single-bus state before applying a different bus count.
- R10: mode_ready never rises earlier than SETTLE_CYCLES cycles after the last change of op_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_multi | input | 1 | 1 requests multi-bus operation |
| req_extra | input | EW (2) | Requested number of borrowed buses |
| dir_write | input | 1 | Transfer direction this cycle, 1 = controller drives data |
| pwr_sw_en | output | MAX_EXTRA (3) | Supply switch enable per borrowable bus |
| dq_rd_en | output | MAX_EXTRA (3) | Read-direction data buffer enable per bus |
| dq_wr_en | output | MAX_EXTRA (3) | Write-direction data buffer enable per bus |
| cmd_drv_en | output | MAX_EXTRA (3) | Command/address buffer enable per bus |
| sel_shared | output | MAX_EXTRA (3) | Device-side switch: shared-bus pair enable |
| sel_private | output | MAX_EXTRA (3) | Device-side switch: private-bus pair enable |
| op_level | output | EW (2) | Operating point index, equal to borrowed bus count |
| mode_ready | output | 1 | Stable single- or multi-bus state reached |

## Verification
In every cycle the bound checker enforces break-before-make between the supply switch and the buffers on each bus, one-hot device-side selection, exclusive data directions, and the rule that no more buses are isolated or driven than the operating point allows. It also enforces, with a counter, that readiness never returns within the settle window after an operating-point change. The exact step-by-step ordering of entry and exit, the edge counts to readiness, the direction-dependent enables, and the deferral of a request changed mid-sequence can only be seen in the bench's directed scenarios, which compare each step against expected values.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

   // Sequencer phases. Entry walks DOWNSHIFT -> ISOLATE -> MULTI,
   // exit walks QUIESCE -> REPOWER -> RESTORE -> SINGLE.
   typedef enum logic [2:0] {
      PH_SINGLE    = 3'd0,
      PH_DOWNSHIFT = 3'd1,
      PH_ISOLATE   = 3'd2,
      PH_MULTI     = 3'd3,
      PH_QUIESCE   = 3'd4,
      PH_REPOWER   = 3'd5,
      PH_RESTORE   = 3'd6
   } pmc_phase_e;

   // Supply pins are closed in every phase except the isolated ones.
   function automatic logic phase_isolated(input pmc_phase_e ph);
      return (ph == PH_ISOLATE) || (ph == PH_MULTI) || (ph == PH_QUIESCE);
   endfunction

   function automatic logic phase_stable(input pmc_phase_e ph);
      return (ph == PH_SINGLE) || (ph == PH_MULTI);
   endfunction

endpackage

// File: rtl/pmc_settle_timer.sv
`timescale 1ns/1ps
module pmc_settle_timer #(
   parameter int SETTLE_CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

   logic [CW-1:0] cnt;

   // Counter restarts from zero whenever the wait phase is not active,
   // so each wait phase lasts exactly SETTLE_CYCLES cycles.
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (cnt != LAST) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = run && (cnt == LAST);

endmodule

// File: rtl/pmc_seq.sv
`timescale 1ns/1ps
module pmc_seq
   import pmc_pkg::*;
#(
   parameter int MAX_EXTRA = 3,
   parameter int EW        = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [EW-1:0] want_extra,
   input  logic          settle_done,
   output pmc_phase_e    phase,
   output logic [EW-1:0] applied_extra,
   output logic [EW-1:0] op_level,
   output logic          timer_run
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase         <= PH_SINGLE;
         applied_extra <= '0;
         op_level      <= '0;
      end else begin
         unique case (phase)
            PH_SINGLE: begin
               if (want_extra != '0) begin
                  // Lower the operating point before anything else.
                  phase         <= PH_DOWNSHIFT;
                  applied_extra <= want_extra;
                  op_level      <= want_extra;
               end
            end
            PH_DOWNSHIFT: if (settle_done) phase <= PH_ISOLATE;
            PH_ISOLATE:   phase <= PH_MULTI;
            PH_MULTI: begin
               if (want_extra != applied_extra) phase <= PH_QUIESCE;
            end
            PH_QUIESCE:   phase <= PH_REPOWER;
            PH_REPOWER: begin
               phase    <= PH_RESTORE;
               op_level <= '0;
            end
            PH_RESTORE: begin
               if (settle_done) begin
                  phase         <= PH_SINGLE;
                  applied_extra <= '0;
               end
            end
            default: begin
               phase         <= PH_SINGLE;
               applied_extra <= '0;
               op_level      <= '0;
            end
         endcase
      end
   end

   assign timer_run = (phase == PH_DOWNSHIFT) || (phase == PH_RESTORE);

endmodule

// File: rtl/pmc_lane.sv
`timescale 1ns/1ps
module pmc_lane #(
   parameter int EW       = 2,
   parameter int LANE_IDX = 0
) (
   input  logic [EW-1:0] applied_extra,
   input  logic          isolated,
   input  logic          live,
   input  logic          dir_write,
   output logic          pwr_sw_en,
   output logic          dq_rd_en,
   output logic          dq_wr_en,
   output logic          cmd_drv_en,
   output logic          sel_shared,
   output logic          sel_private
);
   localparam logic [EW-1:0] IDX = EW'(LANE_IDX);

   logic borrowed;
   logic drive;

   assign borrowed    = (applied_extra > IDX);
   assign drive       = borrowed && live;

   assign pwr_sw_en   = !(borrowed && isolated);
   assign cmd_drv_en  = drive;
   assign dq_rd_en    = drive && !dir_write;
   assign dq_wr_en    = drive &&  dir_write;
   assign sel_private = borrowed && isolated;
   assign sel_shared  = !sel_private;

endmodule

// File: rtl/pin_mode_ctrl.sv
`timescale 1ns/1ps
module pin_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int MAX_EXTRA     = 3,
   parameter int SETTLE_CYCLES = 4000,
   parameter int EW            = $clog2(MAX_EXTRA + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_multi,
   input  logic [EW-1:0]        req_extra,
   input  logic                 dir_write,
   output logic [MAX_EXTRA-1:0] pwr_sw_en,
   output logic [MAX_EXTRA-1:0] dq_rd_en,
   output logic [MAX_EXTRA-1:0] dq_wr_en,
   output logic [MAX_EXTRA-1:0] cmd_drv_en,
   output logic [MAX_EXTRA-1:0] sel_shared,
   output logic [MAX_EXTRA-1:0] sel_private,
   output logic [EW-1:0]        op_level,
   output logic                 mode_ready
);
   localparam logic [EW-1:0] CAP = EW'(MAX_EXTRA);

   if (MAX_EXTRA < 1) begin : g_bad_extra
      $error("MAX_EXTRA must be at least 1");
   end
   if (SETTLE_CYCLES < 2) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 2");
   end
   if (EW < $clog2(MAX_EXTRA + 1)) begin : g_bad_ew
      $error("EW too narrow for MAX_EXTRA");
   end

   pmc_phase_e    phase;
   logic [EW-1:0] want_extra;
   logic [EW-1:0] applied_extra;
   logic          timer_run;
   logic          settle_done;
   logic          isolated;
   logic          live;

   // Effective request: single-bus unless multi is asked with a nonzero count,
   // counts above the borrowable limit saturate.
   always_comb begin
      if (!req_multi)            want_extra = '0;
      else if (req_extra > CAP)  want_extra = CAP;
      else                       want_extra = req_extra;
   end

   pmc_seq #(
      .MAX_EXTRA (MAX_EXTRA),
      .EW        (EW)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .want_extra    (want_extra),
      .settle_done   (settle_done),
      .phase         (phase),
      .applied_extra (applied_extra),
      .op_level      (op_level),
      .timer_run     (timer_run)
   );

   pmc_settle_timer #(
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (timer_run),
      .done  (settle_done)
   );

   assign isolated   = phase_isolated(phase);
   assign live       = (phase == PH_MULTI);
   assign mode_ready = phase_stable(phase);

   for (genvar i = 0; i < MAX_EXTRA; i++) begin : g_lane
      pmc_lane #(
         .EW       (EW),
         .LANE_IDX (i)
      ) u_lane (
         .applied_extra (applied_extra),
         .isolated      (isolated),
         .live          (live),
         .dir_write     (dir_write),
         .pwr_sw_en     (pwr_sw_en[i]),
         .dq_rd_en      (dq_rd_en[i]),
         .dq_wr_en      (dq_wr_en[i]),
         .cmd_drv_en    (cmd_drv_en[i]),
         .sel_shared    (sel_shared[i]),
         .sel_private   (sel_private[i])
      );
   end

endmodule

// File: rtl/pmc_checker.sv
`timescale 1ns/1ps
module pmc_checker #(
   parameter int MAX_EXTRA     = 3,
   parameter int SETTLE_CYCLES = 4000,
   parameter int EW            = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [MAX_EXTRA-1:0] pwr_sw_en,
   input logic [MAX_EXTRA-1:0] dq_rd_en,
   input logic [MAX_EXTRA-1:0] dq_wr_en,
   input logic [MAX_EXTRA-1:0] cmd_drv_en,
   input logic [MAX_EXTRA-1:0] sel_shared,
   input logic [MAX_EXTRA-1:0] sel_private,
   input logic [EW-1:0]        op_level,
   input logic                 mode_ready
);
   localparam int CW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] SAT = CW'(SETTLE_CYCLES);

   logic [EW-1:0] op_q;
   logic [CW-1:0] since_op;

   // Cycles elapsed since op_level last changed, saturating at the window.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q     <= '0;
         since_op <= SAT;
      end else begin
         op_q <= op_level;
         if (op_level != op_q)   since_op <= CW'(1);
         else if (since_op != SAT) since_op <= since_op + 1'b1;
      end
   end

   p_bbm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_sw_en & (dq_rd_en | dq_wr_en | cmd_drv_en)) == '0);

   p_dir_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_rd_en & dq_wr_en) == '0);

   p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_shared ^ sel_private) == {MAX_EXTRA{1'b1}});

   p_drive_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cmd_drv_en) <= int'(op_level));

   p_isolate_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~pwr_sw_en) <= int'(op_level));

   p_settle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_ready) |-> (since_op >= SAT));

   p_ready_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ready |-> ($countones(sel_private) == int'(op_level)));

endmodule

bind pin_mode_ctrl pmc_checker #(
   .MAX_EXTRA     (MAX_EXTRA),
   .SETTLE_CYCLES (SETTLE_CYCLES),
   .EW            (EW)
) u_pmc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_sw_en   (pwr_sw_en),
   .dq_rd_en    (dq_rd_en),
   .dq_wr_en    (dq_wr_en),
   .cmd_drv_en  (cmd_drv_en),
   .sel_shared  (sel_shared),
   .sel_private (sel_private),
   .op_level    (op_level),
   .mode_ready  (mode_ready)
);

// File: tb/pin_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pin_mode_ctrl_bench;
   localparam int NB = 3;
   localparam int S  = 16;
   localparam int EW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_multi = 1'b0;
   logic [EW-1:0] req_extra = '0;
   logic          dir_write = 1'b0;
   logic [NB-1:0] pwr_sw_en, dq_rd_en, dq_wr_en, cmd_drv_en, sel_shared, sel_private;
   logic [EW-1:0] op_level;
   logic          mode_ready;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   pin_mode_ctrl #(
      .MAX_EXTRA     (NB),
      .SETTLE_CYCLES (S)
   ) u_pin_mode_ctrl (
      .clk (clk), .rst_n (rst_n), .req_multi (req_multi), .req_extra (req_extra),
      .dir_write (dir_write), .pwr_sw_en (pwr_sw_en), .dq_rd_en (dq_rd_en),
      .dq_wr_en (dq_wr_en), .cmd_drv_en (cmd_drv_en), .sel_shared (sel_shared),
      .sel_private (sel_private), .op_level (op_level), .mode_ready (mode_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check_single(input string req);
      chk(pwr_sw_en == 3'b111, req, pwr_sw_en, 7);
      chk((dq_rd_en | dq_wr_en | cmd_drv_en) == 3'b000, req, dq_rd_en | dq_wr_en | cmd_drv_en, 0);
      chk(sel_shared == 3'b111 && sel_private == 3'b000, req, sel_private, 0);
      chk(op_level == 2'd0, req, op_level, 0);
   endtask

   task automatic check_multi(input int k, input string req);
      logic [NB-1:0] m;
      m = NB'((1 << k) - 1);
      chk(pwr_sw_en == ~m, req, pwr_sw_en, int'(~m));
      chk(cmd_drv_en == m, req, cmd_drv_en, m);
      chk(dq_rd_en == (dir_write ? 3'b000 : m), req, dq_rd_en, dir_write ? 0 : m);
      chk(dq_wr_en == (dir_write ? m : 3'b000), req, dq_wr_en, dir_write ? m : 0);
      chk(sel_private == m && sel_shared == ~m, req, sel_private, m);
      chk(op_level == EW'(k), req, op_level, k);
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (!mode_ready && n < 1000);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk(mode_ready, "R1", mode_ready, 1);
      check_single("R1");
   endtask

   task automatic t_single_dir();
      dir_write = 1'b1; #1;
      check_single("R3");
      dir_write = 1'b0; #1;
      check_single("R3");
   endtask

   task automatic t_zero_count();
      req_multi = 1'b1;
      req_extra = 2'd0;
      for (int i = 0; i < 8; i++) begin
         step();
         chk(mode_ready, "R5", mode_ready, 1);
      end
      check_single("R5");
      req_multi = 1'b0;
   endtask

   task automatic t_enter(input int k);
      int n;
      logic [NB-1:0] m;
      m = NB'((1 << k) - 1);
      req_multi = 1'b1;
      req_extra = EW'(k);
      step();
      n = 1;
      chk(!mode_ready, "R7", mode_ready, 0);
      chk(op_level == EW'(k), "R7", op_level, k);
      chk(pwr_sw_en == 3'b111 && cmd_drv_en == 3'b000, "R7", pwr_sw_en, 7);
      while (!mode_ready && n < 1000) begin
         if (n == S + 1) begin
            chk(pwr_sw_en == ~m, "R7", pwr_sw_en, int'(~m));
            chk(cmd_drv_en == 3'b000, "R6", cmd_drv_en, 0);
            chk(sel_private == m, "R4", sel_private, m);
         end
         step();
         n++;
      end
      chk(n == S + 2, "R7", n, S + 2);
      dir_write = 1'b0; #1;
      check_multi(k, "R2");
      dir_write = 1'b1; #1;
      check_multi(k, "R3");
      for (int i = 0; i < 4; i++) begin
         dir_write = i[0];
         step();
         check_multi(k, "R2");
      end
      dir_write = 1'b0;
   endtask

   task automatic t_exit(input int k);
      int n;
      logic [NB-1:0] m;
      m = NB'((1 << k) - 1);
      req_multi = 1'b0;
      step();
      n = 1;
      chk(cmd_drv_en == 3'b000 && pwr_sw_en == ~m, "R8", pwr_sw_en, int'(~m));
      chk(op_level == EW'(k), "R8", op_level, k);
      step();
      n++;
      chk(pwr_sw_en == 3'b111 && op_level == EW'(k), "R8", op_level, k);
      step();
      n++;
      chk(op_level == 2'd0 && !mode_ready, "R8", op_level, 0);
      while (!mode_ready && n < 1000) begin
         step();
         n++;
      end
      chk(n == S + 3, "R8", n, S + 3);
      check_single("R8");
   endtask

   task automatic t_hold();
      int n;
      req_multi = 1'b1;
      req_extra = 2'd1;
      step();
      n = 1;
      while (!mode_ready && n < 1000) begin
         if (n == 3) req_extra = 2'd3;
         if (n == 5) req_multi = 1'b0;
         if (n == 6) req_multi = 1'b1;
         step();
         n++;
      end
      chk(n == S + 2, "R9", n, S + 2);
      check_multi(1, "R9");
      wait_ready(n);
      chk(n == S + 3, "R9", n, S + 3);
      check_single("R9");
      wait_ready(n);
      chk(n == S + 2, "R9", n, S + 2);
      check_multi(3, "R9");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_single_dir();
      t_zero_count();
      t_enter(1);
      t_exit(1);
      t_enter(3);
      t_exit(3);
      t_enter(2);
      t_exit(2);
      t_hold();
      t_exit(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule